// File: doc/BRIEF.md
# Serial Audio Port Receiver

This block takes PCM audio from a three-wire serial link (bit clock, frame sync and serial data) and turns it back into left and right sample words. All three lines are sampled by the system clock `clk`, which must run at least four times faster than the bit clock. The block is always a slave to the incoming bit clock and frame sync. Each recovered word is MSB-first and is sign-extended to 24 bits. It leaves the block on `sampleData` with a one-cycle `sampleValid` strobe and a channel flag.

The framing comes from one of two sources. When `regMode` is high, a set of register fields chooses the format: word length, justification, a one-bit data delay, the bit-clock capture edge and the frame-sync polarity. When `regMode` is low, the two `strapSel` pins pick one of four fixed formats. A new format is loaded only when a frame-sync transition is seen, so the half-frame in progress finishes under the format it started with.

Top module: `asp_rx`

## Requirements
- R1: With `regMode`=0, `strapSel` selects the format: 00 = 24-bit left-justified, 01 = 24-bit I2S (one-bit delay, inverted frame sync), 10 = 24-bit right-justified, 11 = 16-bit right-justified. All four capture on the rising bit-clock edge.
- R2: With `regMode`=1, the format comes from the register fields and `strapSel` has no effect. `cfgWordLen` 00/01/10/11 gives 16/18/20/24 bits. `cfgRightJust`=1 selects right-justified placement. `cfgDelay`=1 skips the first captured bit of a half-frame. `cfgFallEdge`=1 captures on the falling edge instead of the rising edge. `cfgInvSync`=1 inverts the frame-sync polarity.
- R3: With non-inverted sync, sync high marks the left channel. With inverted sync, sync low marks the left channel. `sampleRight` is 1 for a right-channel word and 0 for a left-channel word.
- R4: In left-justified placement, the word is the N bits captured MSB-first starting at the frame-sync transition (one bit later when the delay is set). The word is reported as soon as its last bit is in, and later bits in that half-frame are ignored.
- R5: In right-justified placement, the word is the last N bits captured before the next frame-sync transition. It is reported at that transition, and earlier bits in the half-frame are ignored.
- R6: A word shorter than 24 bits is sign-extended from its most significant bit onto `sampleData[23:0]`.
- R7: `sampleValid` is high for exactly one `clk` cycle per word, and `sampleData` changes only together with `sampleValid`.
- R8: A format change on the inputs takes effect at the next frame-sync transition. A change in the middle of a half-frame does not affect that half-frame.
- R9: Reset clears `sampleValid` and `sampleData`. After reset, no word is produced until a frame-sync transition has been seen, so the first, partial half-frame produces nothing.
- R10: A left-justified half-frame that ends before its N data bits have arrived produces no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also samples the serial lines |
| rstN | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Serial bit clock |
| syncIn | input | 1 | Frame sync; each level is one channel half-frame |
| sdata | input | 1 | Serial audio data |
| regMode | input | 1 | 1 = register fields pick the format, 0 = strap pins pick it |
| strapSel | input | 2 | Preset format select |
| cfgWordLen | input | 2 | Register word length code |
| cfgRightJust | input | 1 | Register justification: 1 = right |
| cfgDelay | input | 1 | Register one-bit data delay |
| cfgFallEdge | input | 1 | Register capture edge: 1 = falling |
| cfgInvSync | input | 1 | Register frame-sync inversion |
| sampleValid | output | 1 | One-cycle strobe for a new word |
| sampleData | output | 24 | Sign-extended sample word |
| sampleRight | output | 1 | Channel of the word: 1 = right |

## Verification
All four presets are run with words whose top and bottom bits differ, and the unused slots are filled with alternating junk. A bit taken from the wrong slot, or a wrong delay, therefore changes the result. Two register-mode streams use 18-bit and 20-bit words, falling-edge capture and inverted sync; this separates the capture edge, the polarity and the sign-extension width from the preset decoding. Strap pins are held at a conflicting value during these streams to show they are ignored. A last stream changes the format both at a sync transition and in the middle of a half-frame, then sends a half-frame too short to hold a word. This separates the point at which a new format is loaded, and shows that short left-justified halves are dropped.

// File: rtl/asp_rx_pkg.sv
package asp_rx_pkg;

  typedef struct packed {
    logic [1:0] lenCode;
    logic       rightJust;
    logic       dataDelay;
    logic       fallEdge;
    logic       invSync;
  } fmt_t;

  typedef struct packed {
    logic       capture;    // active bit-clock edge seen this cycle
    logic       halfStart;  // frame-sync level changed at this capture
    logic       bitIn;      // serial bit taken at this capture
    logic       emitLj;     // left-justified word complete
    logic       emitRj;     // right-justified word of previous half complete
    logic [1:0] lenCode;    // word length of the emitted word
    logic       chanRight;  // channel of the emitted word
  } strobe_t;

  function automatic int unsigned wordBits(input logic [1:0] code);
    case (code)
      2'b00:   return 16;
      2'b01:   return 18;
      2'b10:   return 20;
      default: return 24;
    endcase
  endfunction

  function automatic fmt_t strapFmt(input logic [1:0] sel);
    fmt_t f;
    f = '0;
    case (sel)
      2'b00: f.lenCode = 2'b11;
      2'b01: begin f.lenCode = 2'b11; f.dataDelay = 1'b1; f.invSync = 1'b1; end
      2'b10: begin f.lenCode = 2'b11; f.rightJust = 1'b1; end
      default: begin f.lenCode = 2'b00; f.rightJust = 1'b1; end
    endcase
    return f;
  endfunction

endpackage

// File: rtl/asp_rx_ctrl.sv
module asp_rx_ctrl
  import asp_rx_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclkPin,
  input  logic    syncPin,
  input  logic    dataPin,
  input  fmt_t    newFmt,
  output strobe_t strb,
  output fmt_t    activeFmt,
  output logic    halfValid
);

  logic sclkQ, syncQ, dataQ, sclkPrev;
  logic primed, syncPrevCap;
  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] ljLast;
  logic capEdge, syncChange;

  // one register stage on the serial lines, then edge detection
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkQ    <= 1'b0;
      syncQ    <= 1'b0;
      dataQ    <= 1'b0;
      sclkPrev <= 1'b0;
    end else begin
      sclkQ    <= sclkPin;
      syncQ    <= syncPin;
      dataQ    <= dataPin;
      sclkPrev <= sclkQ;
    end
  end

  assign capEdge    = activeFmt.fallEdge ? (sclkPrev & ~sclkQ) : (~sclkPrev & sclkQ);
  assign syncChange = capEdge & primed & (syncQ != syncPrevCap);
  assign ljLast     = CNT_W'(wordBits(activeFmt.lenCode)) + CNT_W'(activeFmt.dataDelay) - CNT_W'(1);

  always_comb begin
    strb.capture   = capEdge;
    strb.halfStart = syncChange;
    strb.bitIn     = dataQ;
    strb.emitLj    = capEdge & halfValid & ~syncChange & ~activeFmt.rightJust & (bitCnt == ljLast);
    strb.emitRj    = syncChange & halfValid & activeFmt.rightJust;
    strb.lenCode   = activeFmt.lenCode;
    strb.chanRight = ~(syncPrevCap ^ activeFmt.invSync);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      primed      <= 1'b0;
      syncPrevCap <= 1'b0;
      bitCnt      <= '0;
      halfValid   <= 1'b0;
    end else if (capEdge) begin
      primed      <= 1'b1;
      syncPrevCap <= syncQ;
      if (syncChange) begin
        bitCnt    <= CNT_W'(1);
        halfValid <= 1'b1;
      end else if (bitCnt != '1) begin
        bitCnt <= bitCnt + CNT_W'(1);
      end
    end
  end

  // format follows the inputs until framing is found, then loads per half-frame
  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeFmt <= '0;
    end else if (!halfValid || syncChange) begin
      activeFmt <= newFmt;
    end
  end

endmodule

// File: rtl/asp_rx_dp.sv
module asp_rx_dp
  import asp_rx_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  output logic              sampleValid,
  output logic [DATA_W-1:0] sampleData,
  output logic              sampleRight,
  output logic [1:0]        outLenCode
);

  localparam int IDX_W = $clog2(DATA_W);
  localparam int LEN_W = IDX_W + 1;

  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] word;
  logic [DATA_W-1:0] extWord;
  logic [LEN_W-1:0]  lenBits;
  logic [IDX_W-1:0]  msbIdx;
  logic              msb;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strb.capture) begin
      if (strb.halfStart) shiftReg <= {{(DATA_W-1){1'b0}}, strb.bitIn};
      else                shiftReg <= {shiftReg[DATA_W-2:0], strb.bitIn};
    end
  end

  assign word    = strb.emitRj ? shiftReg : {shiftReg[DATA_W-2:0], strb.bitIn};
  assign lenBits = LEN_W'(wordBits(strb.lenCode));
  assign msbIdx  = IDX_W'(wordBits(strb.lenCode) - 1);
  assign msb     = word[msbIdx];

  for (genvar i = 0; i < DATA_W; i++) begin : g_ext
    assign extWord[i] = (LEN_W'(i) < lenBits) ? word[i] : msb;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleValid <= 1'b0;
      sampleData  <= '0;
      sampleRight <= 1'b0;
      outLenCode  <= '0;
    end else begin
      sampleValid <= strb.emitLj | strb.emitRj;
      if (strb.emitLj | strb.emitRj) begin
        sampleData  <= extWord;
        sampleRight <= strb.chanRight;
        outLenCode  <= strb.lenCode;
      end
    end
  end

endmodule

// File: rtl/asp_rx.sv
module asp_rx
  import asp_rx_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclk,
  input  logic              syncIn,
  input  logic              sdata,
  input  logic              regMode,
  input  logic [1:0]        strapSel,
  input  logic [1:0]        cfgWordLen,
  input  logic              cfgRightJust,
  input  logic              cfgDelay,
  input  logic              cfgFallEdge,
  input  logic              cfgInvSync,
  output logic              sampleValid,
  output logic [DATA_W-1:0] sampleData,
  output logic              sampleRight
);

  fmt_t    regFmt, newFmt, activeFmt;
  strobe_t strb;
  logic    halfValid;
  logic [1:0] outLenCode;

  always_comb begin
    regFmt.lenCode   = cfgWordLen;
    regFmt.rightJust = cfgRightJust;
    regFmt.dataDelay = cfgDelay;
    regFmt.fallEdge  = cfgFallEdge;
    regFmt.invSync   = cfgInvSync;
    newFmt = regMode ? regFmt : strapFmt(strapSel);
  end

  asp_rx_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .sclkPin   (sclk),
    .syncPin   (syncIn),
    .dataPin   (sdata),
    .newFmt    (newFmt),
    .strb      (strb),
    .activeFmt (activeFmt),
    .halfValid (halfValid)
  );

  asp_rx_dp #(.DATA_W(DATA_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .sampleValid (sampleValid),
    .sampleData  (sampleData),
    .sampleRight (sampleRight),
    .outLenCode  (outLenCode)
  );

endmodule

// File: rtl/asp_rx_chk.sv
module asp_rx_chk
  import asp_rx_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              sampleValid,
  input logic [DATA_W-1:0] sampleData,
  input logic [1:0]        outLenCode,
  input logic              halfValid,
  input strobe_t           strb,
  input fmt_t              activeFmt
);

  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid);

  // R7
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |-> $stable(sampleData));

  // R9
  no_early_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    !halfValid |=> !sampleValid);

  // R8
  fmt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (halfValid && !strb.halfStart) |=> $stable(activeFmt));

  // R6
  sign_ext16_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && outLenCode == 2'b00) |->
      ((&sampleData[DATA_W-1:15]) || !(|sampleData[DATA_W-1:15])));

  // R6
  sign_ext20_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && outLenCode == 2'b10) |->
      ((&sampleData[DATA_W-1:19]) || !(|sampleData[DATA_W-1:19])));

endmodule

bind asp_rx asp_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .sampleValid (sampleValid),
  .sampleData  (sampleData),
  .outLenCode  (outLenCode),
  .halfValid   (halfValid),
  .strb        (strb),
  .activeFmt   (activeFmt)
);

// File: tb/tb_asp_rx.sv
module tb_asp_rx;

  localparam int CLK_PERIOD = 10;
  localparam int SCLK_HALF  = 4;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0, rstN = 1'b0, sclk = 1'b0, syncPin = 1'b0, sdata = 1'b0;
  logic regMode = 1'b0;
  logic [1:0] strapSel = 2'b00, cfgWordLen = 2'b00;
  logic cfgRightJust = 1'b0, cfgDelay = 1'b0, cfgFallEdge = 1'b0, cfgInvSync = 1'b0;
  logic sampleValid, sampleRight;
  logic [23:0] sampleData;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench-side model of the current format
  int mN = 24;
  bit mRj = 0, mD = 0, mFall = 0, mInv = 0;
  // next format for a mid-half change
  logic [1:0] nxCode = 2'b00;
  bit nxRj = 0, nxD = 0;
  // framing state of the model
  bit primedB = 0, syncedB = 0, pendValid = 0, pendRight = 0;
  logic lastLvl = 1'b0;
  logic [23:0] pendWord = '0;
  string pendTag = "";

  logic [23:0] expData[$];
  bit          expRight[$];
  string       expTag[$];
  bit prevV = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  asp_rx dut (
    .clk(clk), .rstN(rstN), .sclk(sclk), .syncIn(syncPin), .sdata(sdata),
    .regMode(regMode), .strapSel(strapSel), .cfgWordLen(cfgWordLen),
    .cfgRightJust(cfgRightJust), .cfgDelay(cfgDelay), .cfgFallEdge(cfgFallEdge),
    .cfgInvSync(cfgInvSync), .sampleValid(sampleValid), .sampleData(sampleData),
    .sampleRight(sampleRight)
  );

  function automatic int lenOf(input logic [1:0] code);
    case (code)
      2'b00: return 16;
      2'b01: return 18;
      2'b10: return 20;
      default: return 24;
    endcase
  endfunction

  function automatic logic [23:0] sext(input logic [23:0] w, input int n);
    logic [23:0] r;
    for (int i = 0; i < 24; i++) r[i] = (i < n) ? w[i] : w[n-1];
    return r;
  endfunction

  task automatic checkEq(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(input logic [23:0] d, input bit r, input string tag);
    expData.push_back(d);
    expRight.push_back(r);
    expTag.push_back(tag);
  endtask

  // R1: preset decoding as stated in the requirement
  task automatic applyStrap(input logic [1:0] sel);
    regMode = 1'b0; strapSel = sel;
    mFall = 0; mRj = sel[1]; mD = (sel == 2'b01); mInv = (sel == 2'b01);
    mN = (sel == 2'b11) ? 16 : 24;
  endtask

  // R2: register fields; strap pins parked on a conflicting value
  task automatic applyReg(input logic [1:0] code, input bit rj, input bit d, input bit f, input bit inv);
    regMode = 1'b1; strapSel = 2'b11;
    cfgWordLen = code; cfgRightJust = rj; cfgDelay = d; cfgFallEdge = f; cfgInvSync = inv;
    mN = lenOf(code); mRj = rj; mD = d; mFall = f; mInv = inv;
  endtask

  task automatic startGroup();
    sclk = mFall;
    @(negedge clk); rstN = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    primedB = 0; syncedB = 0; pendValid = 0;
  endtask

  task automatic endGroup(input string req);
    repeat (20) @(negedge clk);
    checks++;
    if (expData.size() != 0) begin
      errors++;
      $display("FAIL %s: actual %0d words missing expected 0", req, expData.size());
      expData.delete(); expRight.delete(); expTag.delete();
    end
  endtask

  task automatic sendHalf(input logic lvl, input int slots, input logic [23:0] word,
                          input string tag, input int changeAt);
    int hN = mN;
    bit hRj = mRj, hD = mD, hFall = mFall, hInv = mInv;
    bit right;
    if (primedB && lvl != lastLvl) begin
      if (pendValid) push(pendWord, pendRight, pendTag);
      pendValid = 0;
      syncedB = 1;
    end
    primedB = 1; lastLvl = lvl;
    right = ~(lvl ^ hInv);
    if (syncedB) begin
      if (!hRj && slots >= hN + int'(hD)) push(sext(word, hN), right, tag);
      if (hRj && slots >= hN) begin
        pendValid = 1; pendWord = sext(word, hN); pendRight = right; pendTag = tag;
      end
    end
    for (int s = 0; s < slots; s++) begin
      if (s == changeAt) applyReg(nxCode, nxRj, nxD, mFall, mInv);
      syncPin = lvl;
      sclk = hFall;
      if (!hRj) sdata = (s >= int'(hD) && s < int'(hD) + hN) ? word[hN-1-(s-int'(hD))] : s[0];
      else      sdata = (s >= slots - hN) ? word[slots-1-s] : s[0];
      repeat (SCLK_HALF) @(negedge clk);
      sclk = ~hFall;
      repeat (SCLK_HALF) @(negedge clk);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rstN) begin
      prevV = 0;
    end else begin
      if (sampleValid) begin
        checks++;
        if (prevV) begin
          errors++;
          $display("FAIL R7: actual valid for 2 cycles expected 1");
        end
        if (expData.size() == 0) begin
          checks++; errors++;
          $display("FAIL R9 or R10: actual unexpected word %h expected none", sampleData);
        end else begin
          logic [23:0] ed;
          bit er;
          string et;
          ed = expData.pop_front(); er = expRight.pop_front(); et = expTag.pop_front();
          checkEq(et, sampleData, ed);
          checkEq({"R3 channel of ", et}, {23'd0, sampleRight}, {23'd0, er});
        end
      end
      prevV = sampleValid;
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++; errors++;
    $display("FAIL R7 watchdog: actual %0d cycles expected fewer", WATCHDOG);
    finishRun();
  end

  initial begin
    // R9: reset state
    applyStrap(2'b00);
    startGroup();
    @(negedge clk);
    checkEq("R9 reset valid", {23'd0, sampleValid}, 24'd0);
    checkEq("R9 reset data", sampleData, 24'd0);

    // R1 R4: 24-bit left-justified preset; lead-in half gives nothing (R9)
    sendHalf(1'b0, 32, 24'h000000, "R9 lead-in", -1);
    sendHalf(1'b1, 32, 24'h800001, "R1 R4 LJ24 left", -1);
    sendHalf(1'b0, 32, 24'h7F00FF, "R1 R4 LJ24 right", -1);
    sendHalf(1'b1, 32, 24'h123456, "R1 R4 LJ24 left", -1);
    sendHalf(1'b0, 32, 24'hFEDCBA, "R1 R4 LJ24 right", -1);
    endGroup("R1 R4 LJ24");

    // R1 R3: I2S preset, one-bit delay, sync low is left
    applyStrap(2'b01);
    startGroup();
    sendHalf(1'b1, 32, 24'h000000, "R9 lead-in", -1);
    sendHalf(1'b0, 32, 24'hA5A5A5, "R1 R3 I2S left", -1);
    sendHalf(1'b1, 32, 24'h5A5A5A, "R1 R3 I2S right", -1);
    sendHalf(1'b0, 32, 24'h000001, "R1 R3 I2S left", -1);
    endGroup("R1 I2S");

    // R1 R5: 24-bit right-justified preset
    applyStrap(2'b10);
    startGroup();
    sendHalf(1'b0, 32, 24'h000000, "R9 lead-in", -1);
    sendHalf(1'b1, 32, 24'hC00003, "R1 R5 RJ24 left", -1);
    sendHalf(1'b0, 32, 24'h3FFFFC, "R1 R5 RJ24 right", -1);
    sendHalf(1'b1, 4, 24'h000000, "trailer", -1);
    endGroup("R1 R5 RJ24");

    // R1 R5 R6: 16-bit right-justified preset, junk in upper slots
    applyStrap(2'b11);
    startGroup();
    sendHalf(1'b0, 32, 24'h000000, "R9 lead-in", -1);
    sendHalf(1'b1, 32, 24'h008001, "R1 R6 RJ16 left", -1);
    sendHalf(1'b0, 32, 24'h007FFE, "R1 R6 RJ16 right", -1);
    sendHalf(1'b1, 4, 24'h000000, "trailer", -1);
    endGroup("R1 R6 RJ16");

    // R2 R3 R6: 18-bit LJ, falling-edge capture, inverted sync
    applyReg(2'b01, 1'b0, 1'b0, 1'b1, 1'b1);
    startGroup();
    sendHalf(1'b1, 32, 24'h000000, "R9 lead-in", -1);
    sendHalf(1'b0, 32, 24'h020001, "R2 R6 LJ18 fall left", -1);
    sendHalf(1'b1, 32, 24'h01ABCD, "R2 R6 LJ18 fall right", -1);
    endGroup("R2 LJ18");

    // R2 R5: 20-bit RJ, delay set but unused, strap pins ignored
    applyReg(2'b10, 1'b1, 1'b1, 1'b0, 1'b0);
    startGroup();
    sendHalf(1'b0, 24, 24'h000000, "R9 lead-in", -1);
    sendHalf(1'b1, 24, 24'h080000, "R2 R5 RJ20 left", -1);
    sendHalf(1'b0, 24, 24'h07FFFF, "R2 R5 RJ20 right", -1);
    sendHalf(1'b1, 4, 24'h000000, "trailer", -1);
    endGroup("R2 RJ20");

    // R8 R10: format changes at and inside half-frames, then a short half
    applyReg(2'b10, 1'b0, 1'b0, 1'b0, 1'b0);
    startGroup();
    sendHalf(1'b0, 32, 24'h000000, "R9 lead-in", -1);
    sendHalf(1'b1, 32, 24'h0ABCDE, "R8 LJ20", -1);
    applyReg(2'b01, 1'b1, 1'b0, 1'b0, 1'b0);
    sendHalf(1'b0, 32, 24'h02AAAA, "R8 RJ18 after switch", -1);
    nxCode = 2'b11; nxRj = 0; nxD = 0;
    sendHalf(1'b1, 32, 24'h015555, "R8 RJ18 with mid-half change", 5);
    sendHalf(1'b0, 32, 24'h876543, "R8 LJ24 after mid-half change", -1);
    sendHalf(1'b1, 10, 24'hFFFFFF, "R10 short half", -1);
    sendHalf(1'b0, 32, 24'h0F0F0F, "R10 LJ24 after short half", -1);
    endGroup("R8 R10");

    finishRun();
  end

endmodule